// File: doc/BRIEF.md
# Per-Input Edge/Level Interrupt Capture

This block sits in front of a priority-interrupt controller and turns sixteen raw interrupt lines into a vector of latched request bits. The resolver and in-service logic downstream then pick from that vector. Each line has its own sense-mode bit. The bits live in two 8-bit mode registers. A 0 makes the line edge sensitive: only a low-to-high change raises a request. A 1 makes it level sensitive: a request is present while the line is high. There is no controller-wide mode setting. The per-line bits alone decide how each line is sensed.

Every raw line first passes through a two-stage synchroniser. After that, an edge detector and a retention latch produce the request bit. The in-service logic sends a one-cycle clear when it moves a line into service, and a one-cycle end-of-interrupt strobe when it retires that line.

When the controller finishes its first acknowledge pulse, it presents the index of the line it chose. The capture block then checks that line. If the line is still active, the index is confirmed. If the line dropped too early, a spurious result is reported, mapped to line 7.

Top module: `irq_edge_level_capture`

## Requirements
- R1: After reset, both mode registers are zero (all lines edge sensitive), the request vector `reqVec` is zero and `ackValid` is low.
- R2: A line in edge mode (mode bit 0) sets its request bit on a low-to-high change. A line that stays high after its request was cleared by service raises no further request.
- R3: An edge-mode request bit stays set after the line returns low, until a service clear for that line.
- R4: A line in level mode (mode bit 1) has its request bit set while the synchronised line is high. The bit clears when the line falls before service.
- R5: A service clear on a level-mode line clears its request. The request is held off while the line stays high, until an end-of-interrupt strobe for that line. If the line is still high then, the request reappears two cycles after the strobe.
- R6: A write with `cfgWrSel`=0 loads mode bits for lines 0..7, and `cfgWrSel`=1 loads lines 8..15. Data bit i maps to line 8*`cfgWrSel`+i. A write to one register leaves the other register's lines unchanged.
- R7: When `ackFirst` is high and the synchronised line `ackLine` is high, the next cycle shows `ackValid`=1, `ackSpurious`=0 and `ackResult`=`ackLine`. `ackValid` is high only in the cycle after an `ackFirst`.
- R8: When `ackFirst` is high and the synchronised line `ackLine` is low (in either mode), the next cycle shows `ackValid`=1, `ackSpurious`=1 and `ackResult`=7.
- R9: If a new rising edge on an edge-mode line and a service clear for that line land in the same cycle, the request bit ends set.
- R10: A change on a raw line reaches `reqVec` on the third rising clock edge after it. It has not appeared after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqRaw | input | 16 | Raw asynchronous interrupt lines |
| cfgWrEn | input | 1 | Mode register write strobe |
| cfgWrSel | input | 1 | Register select: 0 = lines 0..7, 1 = lines 8..15 |
| cfgWrData | input | 8 | Mode bits, 1 = level, 0 = edge |
| serviceClr | input | 16 | One-hot pulse: line moved into service |
| eoiClr | input | 16 | One-hot pulse: end of interrupt for a line |
| ackFirst | input | 1 | One-cycle strobe at the end of the first acknowledge pulse |
| ackLine | input | 4 | Line chosen by the resolver for this acknowledge |
| reqVec | output | 16 | Latched request bits |
| ackValid | output | 1 | Acknowledge check result valid |
| ackSpurious | output | 1 | The acknowledged line had dropped |
| ackResult | output | 4 | Confirmed line, or 7 when spurious |

## Verification
The hardest situation to reach is a service clear that lands in exactly the cycle where a fresh rising edge is being detected. The stimulus first lets the request settle. It then lowers the line long enough for the synchroniser to flush, raises it again, and fires the service clear on the cycle just before the third clock edge.

The spurious path also needs care. The bench lowers a line, waits for the synchronised copy to go low, and only then issues the acknowledge. It does this once for an edge line whose request is still latched, and once for a line whose request had already cleared. The expected acknowledge results flow through a queue to a monitor.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  localparam int LINE_COUNT    = 16;
  localparam int REG_WIDTH     = 8;
  localparam int REG_COUNT     = LINE_COUNT / REG_WIDTH;
  localparam int SEL_W         = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam int IDX_W         = $clog2(LINE_COUNT);
  localparam int SPURIOUS_LINE = 7;
  localparam int SYNC_DEPTH    = 2;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic             ackNow;
    logic [IDX_W-1:0] ackIdx;
  } ackStrobe_t;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync
  import irq_cap_pkg::*;
#(
  parameter int WIDTH  = LINE_COUNT,
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= rawIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/irq_cap_ctrl.sv
module irq_cap_ctrl
  import irq_cap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [SEL_W-1:0]      cfgWrSel,
  input  logic [REG_WIDTH-1:0]  cfgWrData,
  input  logic                  ackFirst,
  input  logic [IDX_W-1:0]      ackLine,
  output logic [LINE_COUNT-1:0] levelMode,
  output ackStrobe_t            strobes
);
  logic [REG_WIDTH-1:0] modeRegQ [REG_COUNT];

  for (genvar r = 0; r < REG_COUNT; r++) begin : gModeReg
    always_ff @(posedge clk) begin
      if (!rstN)                                  modeRegQ[r] <= '0;
      else if (cfgWrEn && (int'(cfgWrSel) == r))  modeRegQ[r] <= cfgWrData;
    end
    assign levelMode[r*REG_WIDTH +: REG_WIDTH] = modeRegQ[r];

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrEn && int'(cfgWrSel) == r) |=> (levelMode[r*REG_WIDTH +: REG_WIDTH] == $past(cfgWrData))); // R6
    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      !(cfgWrEn && int'(cfgWrSel) == r) |=> $stable(levelMode[r*REG_WIDTH +: REG_WIDTH])); // R6
  end

  always_comb begin
    strobes.ackNow = ackFirst;
    strobes.ackIdx = ackLine;
  end
endmodule

// File: rtl/irq_cap_datapath.sv
module irq_cap_datapath
  import irq_cap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_COUNT-1:0] syncIn,
  input  logic [LINE_COUNT-1:0] levelMode,
  input  ackStrobe_t            strobes,
  input  logic [LINE_COUNT-1:0] serviceClr,
  input  logic [LINE_COUNT-1:0] eoiClr,
  output logic [LINE_COUNT-1:0] reqVec,
  output logic                  ackValid,
  output logic                  ackSpurious,
  output logic [IDX_W-1:0]      ackResult
);
  logic [LINE_COUNT-1:0] prevQ, reqQ, heldQ;
  logic [LINE_COUNT-1:0] riseVec, reqNext, heldNext;
  logic                  ackValidQ, ackSpurQ;
  logic [IDX_W-1:0]      ackResQ;
  logic                  lineLive;

  assign riseVec  = syncIn & ~prevQ;
  assign heldNext = (heldQ | serviceClr) & ~eoiClr;

  for (genvar i = 0; i < LINE_COUNT; i++) begin : gLine
    always_comb begin
      if (levelMode[i]) reqNext[i] = syncIn[i] & ~heldQ[i] & ~serviceClr[i];
      else              reqNext[i] = (reqQ[i] & ~serviceClr[i]) | riseVec[i];
    end

    AST_EDGE_RETAIN: assert property (@(posedge clk) disable iff (!rstN)
      ($past(!levelMode[i] && reqQ[i] && !serviceClr[i])) |-> reqQ[i]); // R3
    AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rstN)
      ($past(levelMode[i] && !syncIn[i])) |-> !reqQ[i]); // R4
    AST_LEVEL_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
      ($past(levelMode[i] && heldQ[i])) |-> !reqQ[i]); // R5
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      ($past(!levelMode[i] && syncIn[i] && !prevQ[i])) |-> reqQ[i]); // R9
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= '0;
      reqQ  <= '0;
      heldQ <= '0;
    end else begin
      prevQ <= syncIn;
      reqQ  <= reqNext;
      heldQ <= heldNext;
    end
  end

  assign lineLive = syncIn[strobes.ackIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValidQ <= 1'b0;
      ackSpurQ  <= 1'b0;
      ackResQ   <= '0;
    end else begin
      ackValidQ <= strobes.ackNow;
      if (strobes.ackNow) begin
        ackSpurQ <= ~lineLive;
        ackResQ  <= lineLive ? strobes.ackIdx : IDX_W'(SPURIOUS_LINE);
      end
    end
  end

  AST_ACK_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ackValidQ |-> $past(strobes.ackNow)); // R7
  AST_SPUR_FROM_DEAD_LINE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackNow |=> (ackSpurQ == !$past(syncIn[strobes.ackIdx]))); // R8

  assign reqVec      = reqQ;
  assign ackValid    = ackValidQ;
  assign ackSpurious = ackSpurQ;
  assign ackResult   = ackResQ;
endmodule

// File: rtl/irq_edge_level_capture.sv
module irq_edge_level_capture
  import irq_cap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_COUNT-1:0] irqRaw,
  input  logic                  cfgWrEn,
  input  logic [SEL_W-1:0]      cfgWrSel,
  input  logic [REG_WIDTH-1:0]  cfgWrData,
  input  logic [LINE_COUNT-1:0] serviceClr,
  input  logic [LINE_COUNT-1:0] eoiClr,
  input  logic                  ackFirst,
  input  logic [IDX_W-1:0]      ackLine,
  output logic [LINE_COUNT-1:0] reqVec,
  output logic                  ackValid,
  output logic                  ackSpurious,
  output logic [IDX_W-1:0]      ackResult
);
  logic [LINE_COUNT-1:0] syncLines;
  logic [LINE_COUNT-1:0] levelMode;
  ackStrobe_t            strobes;

  irq_line_sync #(.WIDTH(LINE_COUNT), .STAGES(SYNC_DEPTH)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (irqRaw),
    .syncOut (syncLines)
  );

  irq_cap_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrSel  (cfgWrSel),
    .cfgWrData (cfgWrData),
    .ackFirst  (ackFirst),
    .ackLine   (ackLine),
    .levelMode (levelMode),
    .strobes   (strobes)
  );

  irq_cap_datapath uDp (
    .clk         (clk),
    .rstN        (rstN),
    .syncIn      (syncLines),
    .levelMode   (levelMode),
    .strobes     (strobes),
    .serviceClr  (serviceClr),
    .eoiClr      (eoiClr),
    .reqVec      (reqVec),
    .ackValid    (ackValid),
    .ackSpurious (ackSpurious),
    .ackResult   (ackResult)
  );
endmodule

// File: tb/irq_edge_level_capture_test.sv
module irq_edge_level_capture_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqRaw = '0;
  logic        cfgWrEn = 1'b0;
  logic [0:0]  cfgWrSel = '0;
  logic [7:0]  cfgWrData = '0;
  logic [15:0] serviceClr = '0;
  logic [15:0] eoiClr = '0;
  logic        ackFirst = 1'b0;
  logic [3:0]  ackLine = '0;
  logic [15:0] reqVec;
  logic        ackValid, ackSpurious;
  logic [3:0]  ackResult;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic       spur;
    logic [3:0] line;
  } expAck_t;
  expAck_t expQ[$];

  always #2.5 clk = ~clk;

  irq_edge_level_capture uut (
    .clk(clk), .rstN(rstN), .irqRaw(irqRaw), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .serviceClr(serviceClr), .eoiClr(eoiClr),
    .ackFirst(ackFirst), .ackLine(ackLine), .reqVec(reqVec), .ackValid(ackValid),
    .ackSpurious(ackSpurious), .ackResult(ackResult)
  );

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeMode(logic sel, logic [7:0] data);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = data;
    cyc(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseService(int line);
    serviceClr[line] = 1'b1;
    cyc(1);
    serviceClr = '0;
  endtask

  // Driver: pushes the expected acknowledge result, then strobes
  task automatic ackCheck(string tag, int line, bit expectLive);
    expAck_t item;
    item.tag  = tag;
    item.spur = !expectLive;
    item.line = expectLive ? 4'(line) : 4'd7;
    expQ.push_back(item);
    ackFirst = 1'b1; ackLine = 4'(line);
    cyc(1);
    ackFirst = 1'b0;
    cyc(1);
  endtask

  // Monitor: pops and compares each acknowledge result
  always @(negedge clk) begin
    if (rstN && ackValid) begin
      if (expQ.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R7 unexpected ackValid actual=1 expected=0");
      end else begin
        expAck_t e;
        e = expQ.pop_front();
        checkVal({e.tag, " spurious"}, 32'(ackSpurious), 32'(e.spur));
        checkVal({e.tag, " line"}, 32'(ackResult), 32'(e.line));
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    checkVal("R1 reqVec after reset", 32'(reqVec), 0);
    checkVal("R1 ackValid after reset", 32'(ackValid), 0);

    // R10 + R2: edge line 3 (reset mode is edge, R1)
    irqRaw[3] = 1'b1;
    cyc(2);
    checkVal("R10 not yet after two edges", 32'(reqVec[3]), 0);
    cyc(1);
    checkVal("R10 R1 edge request on third edge", 32'(reqVec[3]), 1);
    pulseService(3);
    checkVal("R2 service clears edge request", 32'(reqVec[3]), 0);
    cyc(4);
    checkVal("R2 steady high gives no new request", 32'(reqVec[3]), 0);

    // R3: short pulse retained
    irqRaw[5] = 1'b1;
    cyc(2);
    irqRaw[5] = 1'b0;
    cyc(5);
    checkVal("R3 edge request retained after drop", 32'(reqVec[5]), 1);

    // R9: new edge coincides with service clear
    irqRaw[6] = 1'b1; cyc(3);
    checkVal("R9 setup request", 32'(reqVec[6]), 1);
    irqRaw[6] = 1'b0; cyc(3);
    irqRaw[6] = 1'b1; cyc(2);
    pulseService(6);
    checkVal("R9 edge wins over service clear", 32'(reqVec[6]), 1);

    // R6: line 0 and line 10 to level
    writeMode(1'b0, 8'h01);
    writeMode(1'b1, 8'h04);
    irqRaw[0] = 1'b1; irqRaw[10] = 1'b1;
    irqRaw[2] = 1'b1;
    cyc(3);
    checkVal("R6 R4 line0 level request", 32'(reqVec[0]), 1);
    checkVal("R6 line10 level request", 32'(reqVec[10]), 1);
    irqRaw[0] = 1'b0; irqRaw[2] = 1'b0;
    cyc(3);
    checkVal("R4 level request clears on fall", 32'(reqVec[0]), 0);
    checkVal("R6 line2 stays edge mode", 32'(reqVec[2]), 1);

    // R5: level hold-off and re-raise
    pulseService(10);
    checkVal("R5 service clears level request", 32'(reqVec[10]), 0);
    cyc(4);
    checkVal("R5 held off while in service", 32'(reqVec[10]), 0);
    eoiClr[10] = 1'b1; cyc(1); eoiClr = '0;
    cyc(1);
    checkVal("R5 re-raised after end of interrupt", 32'(reqVec[10]), 1);

    // R7 / R8: acknowledge checks
    ackCheck("R7 live edge line3", 3, 1'b1);
    ackCheck("R7 live level line10", 10, 1'b1);
    ackCheck("R8 dropped edge line5", 5, 1'b0);
    ackCheck("R8 dropped level line0", 0, 1'b0);
    ackCheck("R8 dropped latched line2", 2, 1'b0);
    checkVal("R7 ackValid single cycle", 32'(ackValid), 0);
    checkVal("R7 all results seen", 32'(expQ.size()), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule